// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block sits beside a timer's counter and compare logic and chooses which internal event or level is sent on one trigger line to slave timers or to a converter. A three-bit mode field selects the source. Three sources are single-cycle strobes: the software update-generation strobe, the update event, and the channel-1 flag-set attempt. Five sources are levels: the counter enable and the four compare reference levels. The trigger is registered, so it has one clock of latency in every mode.

The same configuration word sets two other routes. The first chooses the timer's first capture input: either the channel-1 pin alone, or the XOR of the channel pins. The second chooses when each channel's DMA request is raised: on that channel's capture/compare event, or on the timer's update event. Software loads the configuration through a single-cycle write strobe.

Top module: `trig_out_sel`

## Requirements
- R1: A synchronous active-high `rst` clears `trig_o` to 0 at the next edge. It also clears every configuration field to 0: mode 000, pin-1 capture, DMA on channel events.
- R2: When `cfg_we` is high at an edge, the configuration takes `cfg_wdata`. Bits [2:0] are the mode, bit 3 is the capture XOR select and bit 4 is the DMA-on-update select. The new mode governs the trigger value loaded at the following edge.
- R3: In mode 000, `trig_o` follows `ug_i`. No other source has any effect in this mode.
- R4: In mode 001, `trig_o` follows the counter-enable level, which is `cen_i` OR `gate_i`.
- R5: In mode 010, `trig_o` follows `upd_i`.
- R6: In mode 011, `trig_o` pulses for every cycle in which `cc1_set_i` is high. Flag-set attempts on consecutive cycles give a pulse on each of those cycles.
- R7: In modes 100, 101, 110 and 111, `trig_o` follows `oc_ref_i[0]`, `[1]`, `[2]` and `[3]` respectively.
- R8: `trig_o` equals the selected source as sampled one clock earlier. A one-cycle strobe therefore gives exactly a one-cycle trigger pulse, and the trigger falls back to 0 on the next cycle.
- R9: `cap_o` is `ch_pin_i[0]` when the capture XOR select is 0. When the select is 1, `cap_o` is the XOR of all `ch_pin_i` bits. The path is combinational.
- R10: When DMA-on-update is 0, `dma_req_o` equals `cc_evt_i`. When it is 1, every bit of `dma_req_o` equals `upd_i`. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word: {dma_upd, cap_xor, mode[2:0]} |
| cen_i | input | 1 | Software counter-enable bit |
| gate_i | input | 1 | Gated-mode trigger input level |
| ug_i | input | 1 | Software update-generation strobe |
| upd_i | input | 1 | Update event strobe |
| cc1_set_i | input | 1 | Channel-1 flag-set attempt strobe |
| oc_ref_i | input | NUM_CMP | Compare reference levels, channel 1 in bit 0 |
| ch_pin_i | input | CAP_PINS | Channel input pins, channel 1 in bit 0 |
| cc_evt_i | input | NUM_DMA | Per-channel capture/compare event strobes |
| trig_o | output | 1 | Registered trigger output |
| cap_o | output | 1 | Selected first capture input |
| dma_req_o | output | NUM_DMA | Per-channel DMA requests |

## Verification
The bench builds the block with its default parameters: four compare references, four DMA channels and three capture pins. These values reach every mode code, including the four reference-level modes. They also make the capture XOR span exactly the three-pin combination, so odd and even pin counts give different results. With four DMA channels, mixed event patterns show per-channel routing, and with update routing selected all four bits must move together.

// File: rtl/tos_pkg.sv
package tos_pkg;
   localparam int MODE_W = 3;
   localparam int CFG_W  = MODE_W + 2;

   typedef enum logic [MODE_W-1:0] {
      TM_UG   = 3'b000,
      TM_EN   = 3'b001,
      TM_UPD  = 3'b010,
      TM_CCP  = 3'b011,
      TM_REF1 = 3'b100,
      TM_REF2 = 3'b101,
      TM_REF3 = 3'b110,
      TM_REF4 = 3'b111
   } tmode_e;

   typedef struct packed {
      logic   dma_upd;
      logic   cap_xor;
      tmode_e mode;
   } cfg_t;
endpackage

// File: rtl/tos_cfg_reg.sv
module tos_cfg_reg
   import tos_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg_q
);
   always_ff @(posedge clk) begin
      if (rst)
         cfg_q <= '0;
      else if (we)
         cfg_q <= cfg_t'(wdata);
   end
endmodule

// File: rtl/tos_trig_sel.sv
module tos_trig_sel
   import tos_pkg::*;
#(
   parameter int NUM_CMP = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  tmode_e             mode,
   input  logic               ug,
   input  logic               cnt_en,
   input  logic               upd,
   input  logic               cc1_set,
   input  logic [NUM_CMP-1:0] oc_ref,
   output logic               trig
);
   logic src;

   always_comb begin
      unique case (mode)
         TM_UG:   src = ug;
         TM_EN:   src = cnt_en;
         TM_UPD:  src = upd;
         TM_CCP:  src = cc1_set;
         default: src = oc_ref[mode[1:0]];
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         trig <= 1'b0;
      else
         trig <= src;
   end
endmodule

// File: rtl/tos_cap_sel.sv
module tos_cap_sel #(
   parameter int CAP_PINS = 3
) (
   input  logic                pick_xor,
   input  logic [CAP_PINS-1:0] pins,
   output logic                cap
);
   logic [CAP_PINS-1:0] acc;

   assign acc[0] = pins[0];
   for (genvar g = 1; g < CAP_PINS; g++) begin : g_xor
      assign acc[g] = acc[g-1] ^ pins[g];
   end

   assign cap = pick_xor ? acc[CAP_PINS-1] : pins[0];
endmodule

// File: rtl/tos_dma_route.sv
module tos_dma_route #(
   parameter int NUM_DMA = 4
) (
   input  logic               on_update,
   input  logic               upd,
   input  logic [NUM_DMA-1:0] cc_evt,
   output logic [NUM_DMA-1:0] req
);
   for (genvar c = 0; c < NUM_DMA; c++) begin : g_ch
      assign req[c] = on_update ? upd : cc_evt[c];
   end
endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
   import tos_pkg::*;
#(
   parameter int NUM_CMP  = 4,
   parameter int NUM_DMA  = 4,
   parameter int CAP_PINS = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic                cen_i,
   input  logic                gate_i,
   input  logic                ug_i,
   input  logic                upd_i,
   input  logic                cc1_set_i,
   input  logic [NUM_CMP-1:0]  oc_ref_i,
   input  logic [CAP_PINS-1:0] ch_pin_i,
   input  logic [NUM_DMA-1:0]  cc_evt_i,
   output logic                trig_o,
   output logic                cap_o,
   output logic [NUM_DMA-1:0]  dma_req_o
);
   localparam int REF_MODES = 1 << (MODE_W - 1);

   if (NUM_CMP != REF_MODES) begin : g_bad_cmp
      $error("NUM_CMP must equal the number of reference modes");
   end
   if (CAP_PINS < 1) begin : g_bad_pins
      $error("CAP_PINS must be at least 1");
   end
   if (NUM_DMA < 1) begin : g_bad_dma
      $error("NUM_DMA must be at least 1");
   end

   cfg_t cfg_q;
   logic cnt_en;

   assign cnt_en = cen_i | gate_i;

   tos_cfg_reg u_cfg (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg_q (cfg_q)
   );

   tos_trig_sel #(.NUM_CMP(NUM_CMP)) u_trig (
      .clk     (clk),
      .rst     (rst),
      .mode    (cfg_q.mode),
      .ug      (ug_i),
      .cnt_en  (cnt_en),
      .upd     (upd_i),
      .cc1_set (cc1_set_i),
      .oc_ref  (oc_ref_i),
      .trig    (trig_o)
   );

   tos_cap_sel #(.CAP_PINS(CAP_PINS)) u_cap (
      .pick_xor (cfg_q.cap_xor),
      .pins     (ch_pin_i),
      .cap      (cap_o)
   );

   tos_dma_route #(.NUM_DMA(NUM_DMA)) u_dma (
      .on_update (cfg_q.dma_upd),
      .upd       (upd_i),
      .cc_evt    (cc_evt_i),
      .req       (dma_req_o)
   );
endmodule

// File: rtl/tos_chk.sv
module tos_chk
   import tos_pkg::*;
#(
   parameter int NUM_CMP  = 4,
   parameter int NUM_DMA  = 4,
   parameter int CAP_PINS = 3
) (
   input logic                clk,
   input logic                rst,
   input logic                cfg_we,
   input logic [CFG_W-1:0]    cfg_wdata,
   input cfg_t                cfg_q,
   input logic                cen_i,
   input logic                gate_i,
   input logic                ug_i,
   input logic                upd_i,
   input logic                cc1_set_i,
   input logic [NUM_CMP-1:0]  oc_ref_i,
   input logic [CAP_PINS-1:0] ch_pin_i,
   input logic [NUM_DMA-1:0]  cc_evt_i,
   input logic                trig_o,
   input logic                cap_o,
   input logic [NUM_DMA-1:0]  dma_req_o
);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!trig_o && cfg_q == '0));

   a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> cfg_q == cfg_t'($past(cfg_wdata)));

   a_r3_ug_mode: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.mode == TM_UG) |=> trig_o == $past(ug_i));

   a_r4_enable_mode: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.mode == TM_EN) |=> trig_o == $past(cen_i | gate_i));

   a_r5_update_mode: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.mode == TM_UPD) |=> trig_o == $past(upd_i));

   a_r6_pulse_mode: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.mode == TM_CCP) |=> trig_o == $past(cc1_set_i));

   a_r7_ref_mode: assert property (@(posedge clk) disable iff (rst)
      cfg_q.mode[2] |=> trig_o == $past(oc_ref_i[cfg_q.mode[1:0]]));

   a_r8_pulse_ends: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.mode == TM_UPD && !upd_i && !cfg_we) |=> !trig_o);

   a_r9_capture: assert property (@(posedge clk) disable iff (rst)
      cap_o == (cfg_q.cap_xor ? ^ch_pin_i : ch_pin_i[0]));

   a_r10_dma: assert property (@(posedge clk) disable iff (rst)
      dma_req_o == (cfg_q.dma_upd ? {NUM_DMA{upd_i}} : cc_evt_i));
endmodule

bind trig_out_sel tos_chk #(
   .NUM_CMP  (NUM_CMP),
   .NUM_DMA  (NUM_DMA),
   .CAP_PINS (CAP_PINS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_q     (cfg_q),
   .cen_i     (cen_i),
   .gate_i    (gate_i),
   .ug_i      (ug_i),
   .upd_i     (upd_i),
   .cc1_set_i (cc1_set_i),
   .oc_ref_i  (oc_ref_i),
   .ch_pin_i  (ch_pin_i),
   .cc_evt_i  (cc_evt_i),
   .trig_o    (trig_o),
   .cap_o     (cap_o),
   .dma_req_o (dma_req_o)
);

// File: tb/sim_trig_out_sel.sv
module sim_trig_out_sel;
   logic       clk = 1'b0;
   logic       rst;
   logic       cfg_we;
   logic [4:0] cfg_wdata;
   logic       cen_i, gate_i, ug_i, upd_i, cc1_set_i;
   logic [3:0] oc_ref_i;
   logic [2:0] ch_pin_i;
   logic [3:0] cc_evt_i;
   logic       trig_o, cap_o;
   logic [3:0] dma_req_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   trig_out_sel u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cen_i(cen_i), .gate_i(gate_i), .ug_i(ug_i), .upd_i(upd_i),
      .cc1_set_i(cc1_set_i), .oc_ref_i(oc_ref_i), .ch_pin_i(ch_pin_i),
      .cc_evt_i(cc_evt_i), .trig_o(trig_o), .cap_o(cap_o),
      .dma_req_o(dma_req_o)
   );

   // {mode[2:0], ug, cen, gate, upd, ccs, oc[3:0], expected trigger}
   localparam int NV = 15;
   localparam logic [12:0] VEC [NV] = '{
      13'b000_1_0_0_0_0_0000_1,  // R3
      13'b000_0_1_1_1_1_1111_0,  // R3 others ignored
      13'b001_0_1_0_0_0_0000_1,  // R4 enable bit
      13'b001_0_0_1_0_0_0000_1,  // R4 gate input
      13'b001_1_0_0_1_1_1111_0,  // R4 both low
      13'b010_0_0_0_1_0_0000_1,  // R5
      13'b010_1_1_1_0_1_1111_0,  // R5 others ignored
      13'b011_0_0_0_0_1_0000_1,  // R6
      13'b011_1_1_1_1_0_1111_0,  // R6 others ignored
      13'b100_0_0_0_0_0_0001_1,  // R7 ch1
      13'b100_1_1_1_1_1_1110_0,  // R7 ch1 low
      13'b101_0_0_0_0_0_0010_1,  // R7 ch2
      13'b110_0_0_0_0_0_0100_1,  // R7 ch3
      13'b111_0_0_0_0_0_1000_1,  // R7 ch4
      13'b111_0_0_0_0_0_0111_0   // R7 ch4 low
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_in();
      cen_i = 0; gate_i = 0; ug_i = 0; upd_i = 0; cc1_set_i = 0;
      oc_ref_i = '0; ch_pin_i = '0; cc_evt_i = '0;
   endtask

   task automatic write_cfg(input logic [4:0] w);
      cfg_we = 1'b1; cfg_wdata = w;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
      clear_in();
      repeat (3) @(posedge clk); #1;
      chk("R1 reset trigger", {3'b0, trig_o}, 4'b0);
      ch_pin_i = 3'b110; cc_evt_i = 4'b1010; upd_i = 1'b1; #1;
      chk("R1 reset capture pin1", {3'b0, cap_o}, 4'b0);
      chk("R1 reset dma on events", dma_req_o, 4'b1010);
      clear_in();
      rst = 1'b0;
      @(posedge clk); #1;

      for (int i = 0; i < NV; i++) begin
         write_cfg({2'b00, VEC[i][12:10]});
         ug_i = VEC[i][9]; cen_i = VEC[i][8]; gate_i = VEC[i][7];
         upd_i = VEC[i][6]; cc1_set_i = VEC[i][5]; oc_ref_i = VEC[i][4:1];
         @(posedge clk); #1;
         chk($sformatf("R2 R8 vector %0d mode %b", i, VEC[i][12:10]),
             {3'b0, trig_o}, {3'b0, VEC[i][0]});
         clear_in();
         if (VEC[i][0] && VEC[i][12:10] inside {3'b000, 3'b010, 3'b011}) begin
            @(posedge clk); #1;
            chk($sformatf("R8 pulse ends vector %0d", i), {3'b0, trig_o}, 4'b0);
         end
      end

      // R6: consecutive flag-set attempts each pulse
      write_cfg(5'b00011);
      cc1_set_i = 1'b1;
      @(posedge clk); #1;
      chk("R6 first attempt", {3'b0, trig_o}, 4'b1);
      @(posedge clk); #1;
      chk("R6 repeat attempt", {3'b0, trig_o}, 4'b1);
      cc1_set_i = 1'b0;
      @(posedge clk); #1;
      chk("R6 after attempts", {3'b0, trig_o}, 4'b0);

      // R2: mode change latency, level held across the write
      cen_i = 1'b1;
      write_cfg(5'b00001);
      chk("R2 old mode still in force", {3'b0, trig_o}, 4'b0);
      @(posedge clk); #1;
      chk("R2 new mode after one edge", {3'b0, trig_o}, 4'b1);
      clear_in();

      // R9: capture selection
      write_cfg(5'b00000);
      ch_pin_i = 3'b110; #1;
      chk("R9 pin1 only, pin1 low", {3'b0, cap_o}, 4'b0);
      ch_pin_i = 3'b001; #1;
      chk("R9 pin1 only, pin1 high", {3'b0, cap_o}, 4'b1);
      write_cfg(5'b01000);
      ch_pin_i = 3'b011; #1;
      chk("R9 xor even", {3'b0, cap_o}, 4'b0);
      ch_pin_i = 3'b111; #1;
      chk("R9 xor three", {3'b0, cap_o}, 4'b1);
      ch_pin_i = 3'b100; #1;
      chk("R9 xor pin3", {3'b0, cap_o}, 4'b1);

      // R10: DMA routing
      write_cfg(5'b00000);
      cc_evt_i = 4'b0101; upd_i = 1'b1; #1;
      chk("R10 event routing", dma_req_o, 4'b0101);
      write_cfg(5'b10000);
      cc_evt_i = 4'b0101; upd_i = 1'b0; #1;
      chk("R10 update routing, no update", dma_req_o, 4'b0000);
      upd_i = 1'b1; #1;
      chk("R10 update routing, update", dma_req_o, 4'b1111);
      clear_in();

      // R1: mid-run reset clears trigger and configuration
      write_cfg(5'b11001);
      cen_i = 1'b1;
      @(posedge clk); #1;
      chk("R4 enable before reset", {3'b0, trig_o}, 4'b1);
      rst = 1'b1;
      @(posedge clk); #1;
      chk("R1 trigger cleared", {3'b0, trig_o}, 4'b0);
      rst = 1'b0;
      ch_pin_i = 3'b110; cc_evt_i = 4'b0011; upd_i = 1'b1;
      @(posedge clk); #1;
      chk("R1 mode cleared", {3'b0, trig_o}, 4'b0);
      chk("R1 capture select cleared", {3'b0, cap_o}, 4'b0);
      chk("R1 dma select cleared", dma_req_o, 4'b0011);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule